// File: doc/BRIEF.md
# Timer-Synchronized Bit-Addressable GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple 8-bit register bus. Software picks, pin by pin, whether a pin is an input or an output. It also picks whether an output drives both levels or acts as an open-drain pull-down. Output data goes through two register stages in a row. A bus write fills the first stage. The second stage drives the pins and copies the first stage either on every clock or only when a chosen one-cycle timer strobe arrives. The choice is made separately for the low and the high nibble, so pin edges can be lined up with a timer.

Each pin also has its own write address, which changes that pin's first-stage bit and no other. The four upper pins can be given to two serial ports: pins 4 and 5 to the second serial port, pins 6 and 7 to the first. Reading the data address returns the pin levels after synchronization. The bus has no handshake: a write takes effect at the clock edge on which `bus_wr` is high, and `bus_rdata` is a combinational view.

Top module: `tsgpio_port`

## Requirements
- R1: After reset every `pin_oe` bit is 0, and both nibbles use immediate transfer. A data write with no other setup reaches the pins as soon as the direction register is written. The mode, drive and alternate registers also reset to 0.
- R2: Direction register at base+7: bit n = 1 makes pin n an output. A pin whose bit is 0 never has `pin_oe` set.
- R3: An output pin with drive-mode bit 0 (standard) has `pin_oe`=1 and `pin_out` equal to its output value, for both levels.
- R4: Drive-mode register at base+6: bit n = 1 makes pin n open-drain. Such an output pin has `pin_oe`=1 and `pin_out`=0 when its value is 0, and `pin_oe`=0 when its value is 1. `pin_out` is always 0 for open-drain pins.
- R5: A write to the data address (base+0) loads the first stage at the write edge. In immediate mode the second stage copies it at the next edge, so the pins change one cycle after the write edge.
- R6: Mode register at base+4, bits 1:0, select the low-nibble transfer: 00 immediate, 01 on `tmr_a1`, 10 on `tmr_b1`, 11 on `tmr_b2`. In a strobe mode the low nibble of the pins copies the first stage only at the edge where the chosen strobe is high. It holds through the other strobes.
- R7: Mode register bits 5:4 select the high-nibble transfer with the same encoding. The two nibbles are independent of each other.
- R8: A write to base+8+n (n = 0..7) sets first-stage bit n to `bus_wdata[n]` and leaves the other seven bits unchanged.
- R9: With `bus_addr` = base, `bus_rdata` equals `pin_in` as it was two clock edges earlier (two-flop synchronizer). Any other address reads 0.
- R10: Alternate register at base+5: bit n (n = 4..7) = 1 puts an alternate output on pin n in place of the second-stage bit. Pins 5:4 take `ser_b_alt[1:0]` and pins 7:6 take `ser_a_alt[1:0]`. Bits 3:0 have no effect. Direction and drive mode still apply to the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (synchronized pins at the data address) |
| tmr_a1 | input | 1 | One-cycle timer strobe, select code 01 |
| tmr_b1 | input | 1 | One-cycle timer strobe, select code 10 |
| tmr_b2 | input | 1 | One-cycle timer strobe, select code 11 |
| ser_a_alt | input | 2 | Alternate outputs for pins 7:6 |
| ser_b_alt | input | 2 | Alternate outputs for pins 5:4 |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The bench builds the block with its defaults: eight pins, base address 0x60 and a two-stage synchronizer. At that size every data byte, every direction byte and every pin-input byte can be swept in full, each with the exact cycle latency checked. All sixteen pairs of nibble transfer modes are run against each of the three strobes. All sixteen alternate-enable masks are crossed with all sixteen serial input values, under both drive modes.

// File: rtl/tsgpio_pkg.sv
package tsgpio_pkg;
  typedef enum logic [1:0] {
    XFER_IMM = 2'b00,
    XFER_TA1 = 2'b01,
    XFER_TB1 = 2'b10,
    XFER_TB2 = 2'b11
  } xfer_sel_e;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_MODE = 4;
  localparam int unsigned OFS_ALT  = 5;
  localparam int unsigned OFS_DRV  = 6;
  localparam int unsigned OFS_DIR  = 7;
  localparam int unsigned OFS_BIT  = 8;
endpackage

// File: rtl/tsgpio_regs.sv
module tsgpio_regs #(
  parameter int unsigned W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  localparam int unsigned NIBS = W / 4,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      stage1,
  output logic [2*NIBS-1:0] xfer_sel,
  output logic [3:0]        alt_en,
  output logic [W-1:0]      od_mode,
  output logic [W-1:0]      dir
);
  import tsgpio_pkg::*;

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(OFS_ALT);
  localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFS_DRV);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_BIT  = ADDR_W'(OFS_BIT);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(OFS_BIT + W);

  logic [ADDR_W-1:0] ofs;
  logic              bit_hit;
  logic [IW-1:0]     bit_idx;

  assign ofs     = addr - BASE;
  assign bit_hit = (ofs >= A_BIT) && (ofs < A_END);
  assign bit_idx = IW'(ofs - A_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      xfer_sel <= '0;
      alt_en   <= '0;
      od_mode  <= '0;
      dir      <= '0;
    end else if (wr_en) begin
      if (ofs == A_DATA) stage1 <= wdata;
      else if (ofs == A_MODE) begin
        xfer_sel[1:0] <= wdata[1:0];
        xfer_sel[3:2] <= wdata[5:4];
      end
      else if (ofs == A_ALT) alt_en <= wdata[7:4];
      else if (ofs == A_DRV) od_mode <= wdata;
      else if (ofs == A_DIR) dir <= wdata;
      else if (bit_hit) stage1[bit_idx] <= wdata[bit_idx];
    end
  end

  // R8: a per-bit write leaves every other first-stage bit alone
  assert_bitwrite_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bit_hit) |=> (((stage1 ^ $past(stage1)) & ~(W'(1) << $past(bit_idx))) == '0));

  // R8: the addressed bit takes the matching write-data bit
  assert_bitwrite_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bit_hit) |=> (stage1[$past(bit_idx)] == $past(wdata[bit_idx])));
endmodule

// File: rtl/tsgpio_xfer.sv
module tsgpio_xfer #(
  parameter int unsigned W = 8,
  localparam int unsigned NIBS = W / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      stage1,
  input  logic [2*NIBS-1:0] xfer_sel,
  input  logic              tmr_a1,
  input  logic              tmr_b1,
  input  logic              tmr_b2,
  output logic [W-1:0]      stage2
);
  import tsgpio_pkg::*;

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    xfer_sel_e sel;
    logic      fire;

    assign sel = xfer_sel_e'(xfer_sel[2*k +: 2]);

    always_comb begin
      unique case (sel)
        XFER_IMM: fire = 1'b1;
        XFER_TA1: fire = tmr_a1;
        XFER_TB1: fire = tmr_b1;
        XFER_TB2: fire = tmr_b2;
        default:  fire = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) stage2[4*k +: 4] <= '0;
      else if (fire) stage2[4*k +: 4] <= stage1[4*k +: 4];
    end

    // R5 / R6 / R7: immediate mode copies the first stage on every edge
    assert_imm_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_sel[2*k +: 2] == 2'b00) |=> (stage2[4*k +: 4] == $past(stage1[4*k +: 4])));

    // R6 / R7: a strobe mode with its strobe low holds the nibble
    assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (((xfer_sel[2*k +: 2] == 2'b01) && !tmr_a1) ||
       ((xfer_sel[2*k +: 2] == 2'b10) && !tmr_b1) ||
       ((xfer_sel[2*k +: 2] == 2'b11) && !tmr_b2)) |=> $stable(stage2[4*k +: 4]));
  end
endmodule

// File: rtl/tsgpio_sync.sv
module tsgpio_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsgpio_pad.sv
module tsgpio_pad #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] stage2,
  input  logic [W-1:0] alt_mask,
  input  logic [W-1:0] alt_val,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] od_mode,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic v;
    assign v          = alt_mask[i] ? alt_val[i] : stage2[i];
    assign pin_out[i] = od_mode[i] ? 1'b0 : v;
    assign pin_oe[i]  = dir[i] & (~od_mode[i] | ~v);
  end
endmodule

// File: rtl/tsgpio_port.sv
module tsgpio_port #(
  parameter int unsigned W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NIBS = W / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              tmr_a1,
  input  logic              tmr_b1,
  input  logic              tmr_b2,
  input  logic [1:0]        ser_a_alt,
  input  logic [1:0]        ser_b_alt,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);
  logic [W-1:0]      stage1, stage2, od_mode, dir, pin_sync;
  logic [2*NIBS-1:0] xfer_sel;
  logic [3:0]        alt_en;
  logic [W-1:0]      alt_mask, alt_val;

  tsgpio_regs #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .stage1(stage1), .xfer_sel(xfer_sel), .alt_en(alt_en), .od_mode(od_mode), .dir(dir)
  );

  tsgpio_xfer #(.W(W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .stage1(stage1), .xfer_sel(xfer_sel),
    .tmr_a1(tmr_a1), .tmr_b1(tmr_b1), .tmr_b2(tmr_b2), .stage2(stage2)
  );

  assign alt_mask = {alt_en, {(W-4){1'b0}}};
  assign alt_val  = {ser_a_alt, ser_b_alt, {(W-4){1'b0}}};

  tsgpio_pad #(.W(W)) u_pad (
    .stage2(stage2), .alt_mask(alt_mask), .alt_val(alt_val),
    .dir(dir), .od_mode(od_mode), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  tsgpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign bus_rdata = (bus_addr == BASE) ? pin_sync : '0;

  // R2: an input pin is never driven
  assert_input_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~dir) == '0));

  // R4: an open-drain pin never drives a high level
  assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & od_mode & pin_out) == '0));

  // R10: an alternate-enabled push-pull output shows its serial value
  assert_alt_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en[3] && dir[W-1] && !od_mode[W-1]) |-> (pin_out[W-1] == ser_a_alt[1]));
endmodule

// File: tb/sim_tsgpio_port.sv
`timescale 1ns/1ps
module sim_tsgpio_port;
  localparam logic [7:0] BASE = 8'h60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = BASE;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tmr_a1 = 1'b0, tmr_b1 = 1'b0, tmr_b2 = 1'b0;
  logic [1:0] ser_a_alt = '0, ser_b_alt = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tsgpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_a1(tmr_a1),
    .tmr_b1(tmr_b1), .tmr_b2(tmr_b2), .ser_a_alt(ser_a_alt),
    .ser_b_alt(ser_b_alt), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = BASE;
  endtask

  function automatic logic [7:0] exp_oe(input logic [7:0] v, input logic [7:0] d, input logic [7:0] od);
    return d & (~od | ~v);
  endfunction

  function automatic logic [7:0] exp_out(input logic [7:0] v, input logic [7:0] od);
    return v & ~od;
  endfunction

  task automatic pulse(input int s);
    @(negedge clk);
    tmr_a1 = (s == 1); tmr_b1 = (s == 2); tmr_b2 = (s == 3);
    @(negedge clk);
    tmr_a1 = 1'b0; tmr_b1 = 1'b0; tmr_b2 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, 8'h00);
    wr(BASE, 8'hC3);
    @(negedge clk);
    chk("R1 dir clear keeps pins hiz", pin_oe, 8'h00);
    wr(BASE + 8'd7, 8'hFF);
    chk("R1 immediate transfer default", pin_out, 8'hC3);
    chk("R1 drive and alt cleared", pin_oe, 8'hFF);

    // R3 / R5: every data byte, push-pull, with one-cycle latency
    cur = 8'hC3;
    for (int v = 0; v < 256; v++) begin
      wr(BASE, 8'(v));
      chk("R5 pins hold before transfer edge", pin_out, cur);
      @(negedge clk);
      chk("R3 push-pull value", pin_out, 8'(v));
      chk("R3 push-pull enable", pin_oe, 8'hFF);
      cur = 8'(v);
    end

    // R2 / R4: every direction byte against two drive patterns
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] data;
      data = pass ? 8'h5A : 8'hA5;
      wr(BASE, data);
      for (int d = 0; d < 256; d++) begin
        logic [7:0] od;
        od = 8'(d) ^ 8'h3C;
        wr(BASE + 8'd7, 8'(d));
        wr(BASE + 8'd6, od);
        chk("R2 R4 enables", pin_oe, exp_oe(data, 8'(d), od));
        chk("R4 open-drain out low", pin_out, exp_out(data, od));
      end
    end
    wr(BASE + 8'd7, 8'hFF);
    wr(BASE + 8'd6, 8'h00);

    // R6 / R7: all select pairs against each strobe
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        logic [7:0] exp, oldv, newv;
        oldv = 8'h69; newv = 8'h96;
        wr(BASE + 8'd4, 8'h00);
        wr(BASE, oldv);
        wr(BASE + 8'd4, {2'b00, 2'(hi), 2'b00, 2'(lo)});
        wr(BASE, newv);
        @(negedge clk);
        exp = oldv;
        if (lo == 0) exp[3:0] = newv[3:0];
        if (hi == 0) exp[7:4] = newv[7:4];
        chk("R6 R7 after write", pin_out, exp);
        for (int s = 1; s < 4; s++) begin
          pulse(s);
          if (lo == s) exp[3:0] = newv[3:0];
          if (hi == s) exp[7:4] = newv[7:4];
          chk(s == 1 ? "R6 R7 strobe a1" : (s == 2 ? "R6 R7 strobe b1" : "R6 R7 strobe b2"),
              pin_out, exp);
        end
      end
    end
    wr(BASE + 8'd4, 8'h00);

    // R8: per-bit writes with inverted neighbours
    wr(BASE, 8'h00);
    cur = 8'h00;
    for (int pass = 0; pass < 2; pass++) begin
      for (int n = 0; n < 8; n++) begin
        wr(BASE + 8'd8 + 8'(n), ~cur);
        cur[n] = ~cur[n];
        @(negedge clk);
        chk("R8 per-bit write", pin_out, cur);
      end
    end

    // R9: every pin byte through the synchronizer
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = pin_in;
      @(negedge clk);
      pin_in = 8'(v);
      @(negedge clk);
      chk("R9 one edge still old", bus_rdata, prev);
      @(negedge clk);
      chk("R9 readback after two edges", bus_rdata, 8'(v));
    end
    @(negedge clk);
    bus_addr = BASE + 8'd1;
    #1;
    chk("R9 other address reads zero", bus_rdata, 8'h00);
    bus_addr = BASE;

    // R10: all alternate masks against all serial values, both drive modes
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] data, od;
      data = pass ? 8'hFF : 8'h00;
      od   = pass ? 8'hFF : 8'h00;
      wr(BASE, data);
      wr(BASE + 8'd6, od);
      for (int m = 0; m < 16; m++) begin
        wr(BASE + 8'd5, {4'(m), 4'hF});
        for (int a = 0; a < 16; a++) begin
          logic [7:0] mask, altv, v;
          @(negedge clk);
          ser_a_alt = 2'(a >> 2); ser_b_alt = 2'(a);
          #1;
          mask = {4'(m), 4'h0};
          altv = {4'(a), 4'h0};
          v = (mask & altv) | (~mask & data);
          chk("R10 alternate out", pin_out, exp_out(v, od));
          chk("R10 alternate enable", pin_oe, exp_oe(v, 8'hFF, od));
        end
      end
    end

    finish_run();
  end
endmodule